// File: doc/BRIEF.md
# Status Register Move Unit

This unit carries out the two move operations between a 64-bit general register port and the lower window of a 64-bit processor status register, which the unit holds itself. A request arrives as a one-cycle valid pulse carrying a qualifying predicate, a direction bit, a target register index, a 64-bit source value and the source's not-a-thing (NaT) flag. A read places a masked copy of the status register on the destination port. A write replaces the low 32 status bits with the low 32 source bits.

Before any update the unit checks for faults. It uses a fixed priority order for each direction and reports only the highest-priority fault, as a 3-bit code with a strobe. A faulting or unqualified request changes nothing. The privilege-level field (bits 33:32) and the virtualization bit (bit 46) are read from the status register itself. They can only be set by reset or by a test load port.

Top module: `sreg_move_unit`

## Requirements
- R1: While and after reset the status register holds the parameter `RST_VAL` (default zero), and `done`, `fault` and `dst_we` are low with `fault_code` 0.
- R2: A successful read drives `dst_data` with status bits 31:0 and 36:35 in their own positions and every other bit zero (bits 63:37 and 34:32 always read zero). It pulses `dst_we` with `dst_idx` equal to the target and `dst_nat` low.
- R3: A successful write sets status bits 31:0 to source bits 31:0, leaves status bits 63:32 unchanged, and source bits 63:32 have no effect.
- R4: A request with the qualifying predicate low raises no fault, pulses neither `done` nor `dst_we`, and leaves the status register unchanged.
- R5: Read faults are checked in this order: target index 0 gives code 1 (illegal operation), then a nonzero privilege field gives code 2 (privileged operation), then vm set gives code 3 (virtualization).
- R6: Write faults are checked in this order: nonzero privilege field gives code 2, then source NaT set gives code 4 (NaT consumption), then a reserved-field violation gives code 5, then vm set gives code 3.
- R7: A write has a reserved-field violation when source bits 31:0 ANDed with the parameter `RSVD_MASK` (default 32'hF000_0001) are nonzero. Source bits 63:32 are never checked.
- R8: A faulting request makes no update: the status register is unchanged and `dst_we` stays low.
- R9: Outcomes appear one cycle after the request. Each qualified request pulses exactly one of `done` or `fault`, and `fault_code` is 0 whenever `fault` is low.
- R10: `tload_en` loads all 64 status bits from `tload_val` on the next edge, and it overrides a write request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_qp | input | 1 | Qualifying predicate |
| req_dir | input | 1 | 0 = read status, 1 = write status |
| req_tgt | input | 7 | Destination register index for a read |
| req_src | input | 64 | Source value for a write |
| req_src_nat | input | 1 | NaT flag of the source |
| tload_en | input | 1 | Test load enable |
| tload_val | input | 64 | Test load value |
| done | output | 1 | Request completed without fault |
| dst_we | output | 1 | Destination write strobe (read form) |
| dst_idx | output | 7 | Destination register index |
| dst_data | output | 64 | Destination value |
| dst_nat | output | 1 | Destination NaT flag, always 0 |
| fault | output | 1 | Fault strobe |
| fault_code | output | 3 | Fault code, 0 when none |
| sreg | output | 64 | Current status register |

## Verification
Each fault-ordering vector preloads a status value and sets more than one fault condition, so that only the intended fault is the highest-priority one. This distinguishes a correct priority order from a swapped one in both directions. The clean read uses a preload with every bit set that can be set without a fault, which shows whether bits outside the window leak through. The clean writes carry nonzero upper source bits and a nonzero upper status half, so a write that is not masked, or a reserved check that covers too many bits, changes the result. Directed cases cover reset, unqualified requests, and a test load that collides with a write.

// File: rtl/sreg_move_pkg.sv
package sreg_move_pkg;
  localparam int XLEN   = 64;
  localparam int LO_W   = 32;
  localparam int IDX_W  = 7;
  localparam int CPL_LO = 32;
  localparam int VM_BIT = 46;
  // read window: low word plus bits 36:35
  localparam logic [XLEN-1:0] READ_MASK = 64'h0000_0018_FFFF_FFFF;

  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_ILLEGAL = 3'd1,
    FC_PRIV    = 3'd2,
    FC_VIRT    = 3'd3,
    FC_NAT     = 3'd4,
    FC_RSVD    = 3'd5
  } fault_e;
endpackage

// File: rtl/sreg_state.sv
module sreg_state
  import sreg_move_pkg::*;
#(
  parameter logic [XLEN-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_en,
  input  logic [XLEN-1:0] ld_val,
  input  logic            wr_en,
  input  logic [LO_W-1:0] wr_lo,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (ld_en) q <= ld_val;
    else if (wr_en) q[LO_W-1:0] <= wr_lo;
  end

  p_tload_r10: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> q == $past(ld_val));
  p_upper_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ld_en) |=> q[XLEN-1:LO_W] == $past(q[XLEN-1:LO_W]));
endmodule

// File: rtl/sreg_fault_arb.sv
module sreg_fault_arb
  import sreg_move_pkg::*;
#(
  parameter logic [LO_W-1:0] RSVD_MASK = 32'hF000_0001
) (
  input  logic             qual,
  input  logic             dir,
  input  logic [IDX_W-1:0] tgt,
  input  logic [LO_W-1:0]  src_lo,
  input  logic             nat,
  input  logic [1:0]       cpl,
  input  logic             vm,
  output fault_e           code
);
  logic priv_bad, rsvd_bad;
  assign priv_bad = (cpl != 2'd0);
  assign rsvd_bad = |(src_lo & RSVD_MASK);

  always_comb begin
    code = FC_NONE;
    if (qual) begin
      if (!dir) begin
        if (tgt == '0)    code = FC_ILLEGAL;
        else if (priv_bad) code = FC_PRIV;
        else if (vm)       code = FC_VIRT;
      end else begin
        if (priv_bad)      code = FC_PRIV;
        else if (nat)      code = FC_NAT;
        else if (rsvd_bad) code = FC_RSVD;
        else if (vm)       code = FC_VIRT;
      end
    end
  end

  always_comb begin
    if (qual && dir && !priv_bad && !nat)
      a_rsvd_r7: assert (rsvd_bad == (code == FC_RSVD));
  end
endmodule

// File: rtl/sreg_read_fmt.sv
module sreg_read_fmt
  import sreg_move_pkg::*;
(
  input  logic [XLEN-1:0] sreg_in,
  output logic [XLEN-1:0] rd_out
);
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    if (READ_MASK[i]) begin : g_keep
      assign rd_out[i] = sreg_in[i];
    end else begin : g_zero
      assign rd_out[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sreg_move_unit.sv
module sreg_move_unit
  import sreg_move_pkg::*;
#(
  parameter logic [XLEN-1:0] RST_VAL   = '0,
  parameter logic [LO_W-1:0] RSVD_MASK = 32'hF000_0001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_qp,
  input  logic             req_dir,
  input  logic [IDX_W-1:0] req_tgt,
  input  logic [XLEN-1:0]  req_src,
  input  logic             req_src_nat,
  input  logic             tload_en,
  input  logic [XLEN-1:0]  tload_val,
  output logic             done,
  output logic             dst_we,
  output logic [IDX_W-1:0] dst_idx,
  output logic [XLEN-1:0]  dst_data,
  output logic             dst_nat,
  output logic             fault,
  output logic [2:0]       fault_code,
  output logic [XLEN-1:0]  sreg
);
  logic            qual, ok, wr_commit;
  fault_e          code;
  logic [XLEN-1:0] rd_val;
  logic [XLEN-1:0] sreg_q;

  assign qual      = req_valid && req_qp;
  assign ok        = qual && (code == FC_NONE);
  assign wr_commit = ok && req_dir;

  sreg_fault_arb #(.RSVD_MASK(RSVD_MASK)) u_arb (
    .qual  (qual),
    .dir   (req_dir),
    .tgt   (req_tgt),
    .src_lo(req_src[LO_W-1:0]),
    .nat   (req_src_nat),
    .cpl   (sreg_q[CPL_LO +: 2]),
    .vm    (sreg_q[VM_BIT]),
    .code  (code)
  );

  sreg_read_fmt u_fmt (
    .sreg_in(sreg_q),
    .rd_out (rd_val)
  );

  sreg_state #(.RST_VAL(RST_VAL)) u_state (
    .clk   (clk),
    .rst   (rst),
    .ld_en (tload_en),
    .ld_val(tload_val),
    .wr_en (wr_commit),
    .wr_lo (req_src[LO_W-1:0]),
    .q     (sreg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      dst_we     <= 1'b0;
      dst_idx    <= '0;
      dst_data   <= '0;
      fault      <= 1'b0;
      fault_code <= 3'd0;
    end else begin
      done       <= ok;
      dst_we     <= ok && !req_dir;
      dst_idx    <= req_tgt;
      dst_data   <= (ok && !req_dir) ? rd_val : '0;
      fault      <= qual && (code != FC_NONE);
      fault_code <= qual ? code : FC_NONE;
    end
  end

  assign dst_nat = 1'b0;
  assign sreg    = sreg_q;

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, fault}));
  p_code_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !fault |-> fault_code == 3'd0);
  p_qp_false_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_qp) |=> (!done && !fault && !dst_we));
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (qual && code != FC_NONE && !tload_en) |=> (sreg == $past(sreg) && !dst_we));
  p_read_window_r2: assert property (@(posedge clk) disable iff (rst)
    dst_we |-> ((dst_data & ~READ_MASK) == '0 && dst_nat == 1'b0));
endmodule

// File: tb/sreg_move_unit_bench.sv
`timescale 1ns/1ps
module sreg_move_unit_bench;
  typedef struct packed {
    logic [63:0] pre;
    logic        dir;
    logic [6:0]  tgt;
    logic [63:0] src;
    logic        nat;
    logic [2:0]  code;
  } vec_t;

  localparam logic [63:0] WIN = 64'h0000_0018_FFFF_FFFF;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{64'hFFFF_BFFC_FFFF_FFFF, 1'b0, 7'd5,  64'h0,                   1'b0, 3'd0}, // R2 clean read, all legal bits set
    '{64'h0000_4003_0000_0000, 1'b0, 7'd0,  64'h0,                   1'b0, 3'd1}, // R5 illegal beats priv, vm
    '{64'h0000_4003_0000_0000, 1'b0, 7'd9,  64'h0,                   1'b0, 3'd2}, // R5 priv beats vm
    '{64'h0000_4000_0000_1234, 1'b0, 7'd9,  64'h0,                   1'b0, 3'd3}, // R5 vm alone
    '{64'h0000_4001_0000_0000, 1'b1, 7'd0,  64'h0000_0000_F000_0001, 1'b1, 3'd2}, // R6 priv first
    '{64'h0000_4000_0000_0000, 1'b1, 7'd0,  64'h0000_0000_F000_0001, 1'b1, 3'd4}, // R6 nat beats rsvd, vm
    '{64'h0000_4000_0000_0000, 1'b1, 7'd0,  64'h0000_0000_F000_0001, 1'b0, 3'd5}, // R6 rsvd beats vm
    '{64'h0000_4000_0000_0000, 1'b1, 7'd0,  64'h0000_0000_0000_0ABC, 1'b0, 3'd3}, // R6 vm last
    '{64'h1234_0000_5555_5555, 1'b1, 7'd0,  64'hDEAD_BEEF_0ABC_DE10, 1'b0, 3'd0}, // R3 clean write
    '{64'h0000_0000_0000_0000, 1'b1, 7'd0,  64'hFFFF_FFFF_0000_0002, 1'b0, 3'd0}, // R7 upper src never checked
    '{64'h0000_0008_1234_5678, 1'b0, 7'd33, 64'h0,                   1'b0, 3'd0}, // R2 bit 35 read
    '{64'h0000_0000_0000_0000, 1'b1, 7'd0,  64'h0000_0000_0000_0001, 1'b0, 3'd5}  // R7 single reserved bit
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_qp, req_dir, req_src_nat, tload_en;
  logic [6:0]  req_tgt;
  logic [63:0] req_src, tload_val;
  logic        done, dst_we, dst_nat, fault;
  logic [6:0]  dst_idx;
  logic [63:0] dst_data, sreg;
  logic [2:0]  fault_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sreg_move_unit u_sreg_move_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_qp(req_qp),
    .req_dir(req_dir), .req_tgt(req_tgt), .req_src(req_src),
    .req_src_nat(req_src_nat), .tload_en(tload_en), .tload_val(tload_val),
    .done(done), .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
    .dst_nat(dst_nat), .fault(fault), .fault_code(fault_code), .sreg(sreg)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [63:0] v);
    @(negedge clk);
    tload_en = 1'b1; tload_val = v;
    @(negedge clk);
    tload_en = 1'b0;
  endtask

  // drives a request for one cycle; on return, outputs of that request are visible
  task automatic issue(input logic qp, input logic dir, input logic [6:0] tgt,
                       input logic [63:0] src, input logic nat);
    req_valid = 1'b1; req_qp = qp; req_dir = dir; req_tgt = tgt;
    req_src = src; req_src_nat = nat;
    @(negedge clk);
    req_valid = 1'b0; req_qp = 1'b0;
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_qp = 1'b0; req_dir = 1'b0;
    req_tgt = '0; req_src = '0; req_src_nat = 1'b0;
    tload_en = 1'b0; tload_val = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 sreg", sreg, 64'h0);
    chk("R1 strobes", {61'h0, done, fault, dst_we}, 64'h0);
    chk("R1 code", {61'h0, fault_code}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      logic [63:0] exp_sreg;
      v = VECS[i];
      tag = (v.code == 3'd0) ? (v.dir ? "R3" : "R2") :
            (v.code == 3'd5) ? "R7" : (v.dir ? "R6" : "R5");
      exp_sreg = (v.code == 3'd0 && v.dir) ? {v.pre[63:32], v.src[31:0]} : v.pre;
      preload(v.pre);
      issue(1'b1, v.dir, v.tgt, v.src, v.nat);
      chk({tag, " code"}, {61'h0, fault_code}, {61'h0, v.code});
      chk({tag, " R9 strobes"}, {62'h0, done, fault}, {62'h0, v.code == 3'd0, v.code != 3'd0});
      chk({tag, " R8 sreg"}, sreg, exp_sreg);
      chk({tag, " dst_we"}, {63'h0, dst_we}, {63'h0, v.code == 3'd0 && !v.dir});
      if (v.code == 3'd0 && !v.dir) begin
        chk("R2 data", dst_data, v.pre & WIN);
        chk("R2 idx nat", {56'h0, dst_idx, dst_nat}, {56'h0, v.tgt, 1'b0});
      end
      @(negedge clk);
      chk({tag, " R9 one pulse"}, {62'h0, done, fault}, 64'h0);
    end

    // R4 unqualified write with all fault causes present
    preload(64'h0000_4003_0000_00AA);
    issue(1'b0, 1'b1, 7'd0, 64'hFFFF_FFFF_F000_0001, 1'b1);
    chk("R4 write strobes", {61'h0, done, fault, dst_we}, 64'h0);
    chk("R4 write sreg", sreg, 64'h0000_4003_0000_00AA);
    // R4 unqualified read
    preload(64'h0000_0000_0000_0777);
    issue(1'b0, 1'b0, 7'd4, 64'h0, 1'b0);
    chk("R4 read strobes", {61'h0, done, fault, dst_we}, 64'h0);
    chk("R4 read sreg", sreg, 64'h0000_0000_0000_0777);

    // R10 test load collides with a write
    @(negedge clk);
    tload_en = 1'b1; tload_val = 64'h0000_0000_CAFE_0000;
    issue(1'b1, 1'b1, 7'd0, 64'h0000_0000_0000_1110, 1'b0);
    tload_en = 1'b0;
    chk("R10 load wins", sreg, 64'h0000_0000_CAFE_0000);

    // R2 read after write: upper window stays zero
    preload(64'hFFFF_BFFC_0000_0000);
    issue(1'b1, 1'b1, 7'd0, 64'h0000_0000_0ABC_DEF0, 1'b0);
    issue(1'b1, 1'b0, 7'd127, 64'h0, 1'b0);
    chk("R2 read after write", dst_data, 64'h0000_0018_0ABC_DEF0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule